// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

An 8-bit up-counter advances once per tick. The tick comes either from a power-of-two divider on the system clock or from rising edges on an external event pin. The pin is synchronized and edge-detected before it is counted.

In wrap mode the counter runs freely and rolls over from the maximum value to zero. In clear mode it restarts from zero after it reaches a compare value, so the period is the input clock divided by the prescale ratio and by (compare + 1).

Two event flags record overflow and compare match. Each flag stays set until it is cleared. An interrupt request combines the flags with per-source enables and a global enable. A compare output pin reacts to each match.

All configuration goes through a small parallel write port. Bit positions and register addresses are given in the requirements below.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, both flags, the interrupt request and the compare pin are all 0.
- R2: Address 0 is the control register. Its fields are: bit 0 run enable, bit 1 mode (0 wrap, 1 clear), bits 3:2 prescale select, bit 4 source (0 clock, 1 pin), bits 6:5 pin action. With the clock source, the count advances once every 1, 8, 64 or 512 cycles for select 0 to 3. While disabled the count holds and the divider returns to zero, so the first tick after enabling comes a full ratio later.
- R3: With the pin source, each rising edge of the external pin advances the count by exactly one, a few cycles later. A level that is held high counts once, and clock cycles are not counted.
- R4: In wrap mode the count goes from the maximum value to 0 and never restarts early. The overflow flag reads 1 in the same cycle that the count first reads 0, so the overflow period is 256 ticks.
- R5: Address 1 holds the compare value. A tick that finds the count equal to it is a match and sets the compare flag. In clear mode that tick loads 0, so a match recurs every compare+1 ticks.
- R6: If the compare value is below the current count in clear mode, the count runs up to the maximum value, wraps and raises the overflow flag. It then matches on the following pass.
- R7: Both flags are sticky. Writing address 3 with bit 4 set clears the overflow flag, and with bit 5 set clears the compare flag.
- R8: An event in the same cycle as a clear of its flag leaves the flag set.
- R9: Address 3 bits 0, 1 and 2 are the overflow enable, the compare enable and the global enable. The interrupt request is high when the global enable is set and an enabled flag is set. An acknowledge with the global enable set clears the enabled compare flag first, or else the enabled overflow flag. Without the global enable, an acknowledge has no effect.
- R10: On each match the pin action applies: 01 toggles the pin, 10 drives it to 0, 11 drives it to 1, and 00 leaves it unchanged.
- R11: Writing address 2 loads the count and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_addr | input | 2 | Register address |
| ctl_wdata | input | CNT_W | Register write data |
| ext_evt_i | input | 1 | External event pin, asynchronous |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| cmp_pin_o | output | 1 | Compare output pin |
| count_o | output | CNT_W | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a divider step of 3 bits and two synchronizer stages. With the 8-bit count the whole range is cheap to cover, so every compare value from 0 to 255 is swept in clear mode with the ratio-1 clock. Each measured toggle interval is checked against compare+1. All four prescale ratios stay within a few thousand cycles, so each one is timed directly, along with the divider restart after a disable. Exact cycle counts are checked for wrap-around, the lowered compare value and a flag clear that collides with an event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      PIN_HOLD   = 2'b00,
      PIN_TOGGLE = 2'b01,
      PIN_CLEAR  = 2'b10,
      PIN_SET    = 2'b11
   } pin_act_t;

   typedef enum logic {
      MODE_WRAP = 1'b0,
      MODE_CLR  = 1'b1
   } cnt_mode_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CMP  = 2'd1;
   localparam logic [1:0] ADDR_CNT  = 2'd2;
   localparam logic [1:0] ADDR_IRQ  = 2'd3;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int PRE_STEP    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] sel,
   input  logic       ext_src,
   input  logic       ext_pin,
   output logic       tick
);
   localparam int PRE_W = PRE_STEP * 3;

   logic [PRE_W-1:0] div_q;
   logic [PRE_W-1:0] div_lim;
   logic             clk_tick;
   logic             ext_tick;
   logic             edge_q;
   logic [SYNC_STAGES-1:0] sync_q;

   // Ratio 2^(PRE_STEP*sel); the top select wraps to all ones.
   always_comb begin
      div_lim = (PRE_W'(1) << (PRE_STEP * int'(sel))) - PRE_W'(1);
   end

   assign clk_tick = en && (div_q == div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (!en)      div_q <= '0;
      else if (clk_tick) div_q <= '0;
      else               div_q <= div_q + PRE_W'(1);
   end

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= ext_pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_q <= 1'b0;
      else        edge_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_tick = en && sync_q[SYNC_STAGES-1] && !edge_q;
   assign tick     = ext_src ? ext_tick : clk_tick;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  cnt_mode_t        mode,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] count,
   output logic             ovf_evt,
   output logic             cmp_evt
);
   logic adv;
   logic at_max;
   logic at_cmp;

   assign at_max  = (count == {CNT_W{1'b1}});
   assign at_cmp  = (count == cmp_val);
   assign adv     = tick && !cnt_we;
   assign ovf_evt = adv && at_max;
   assign cmp_evt = adv && at_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                count <= '0;
      else if (cnt_we)                           count <= cnt_wdata;
      else if (adv && mode == MODE_CLR && at_cmp) count <= '0;
      else if (adv)                              count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
   import tmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ovf_evt,
   input  logic     cmp_evt,
   input  logic     clr_ovf,
   input  logic     clr_cmp,
   input  logic     ack,
   input  logic     gie,
   input  logic     ovf_ie,
   input  logic     cmp_ie,
   input  pin_act_t pin_act,
   output logic     ovf_flag,
   output logic     cmp_flag,
   output logic     irq,
   output logic     pin
);
   logic ack_cmp;
   logic ack_ovf;

   assign ack_cmp = ack && gie && cmp_ie && cmp_flag;
   assign ack_ovf = ack && gie && ovf_ie && ovf_flag && !ack_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovf_flag <= 1'b0;
      else if (ovf_evt)            ovf_flag <= 1'b1;
      else if (clr_ovf || ack_ovf) ovf_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cmp_flag <= 1'b0;
      else if (cmp_evt)            cmp_flag <= 1'b1;
      else if (clr_cmp || ack_cmp) cmp_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else if (cmp_evt) begin
         case (pin_act)
            PIN_TOGGLE: pin <= !pin;
            PIN_CLEAR:  pin <= 1'b0;
            PIN_SET:    pin <= 1'b1;
            default:    pin <= pin;
         endcase
      end
   end

   assign irq = gie && ((ovf_ie && ovf_flag) || (cmp_ie && cmp_flag));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_STEP    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [1:0]       ctl_addr,
   input  logic [CNT_W-1:0] ctl_wdata,
   input  logic             ext_evt_i,
   input  logic             irq_ack_i,
   output logic             irq_o,
   output logic             cmp_pin_o,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_flag_o,
   output logic             cmp_flag_o
);
   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("cmp_timer: CNT_W must be at least 8 to hold the control fields");
      end
      if (PRE_STEP < 1) begin : g_bad_step
         $error("cmp_timer: PRE_STEP must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cmp_timer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             en_q;
   cnt_mode_t        mode_q;
   logic [1:0]       sel_q;
   logic             ext_q;
   pin_act_t         pin_act_q;
   logic [CNT_W-1:0] cmp_q;
   logic             ovf_ie_q;
   logic             cmp_ie_q;
   logic             gie_q;

   logic wr_ctrl, wr_cmp, wr_cnt, wr_irq;
   logic tick, ovf_evt, cmp_evt;
   logic unused_wbits;

   assign wr_ctrl = ctl_we && (ctl_addr == ADDR_CTRL);
   assign wr_cmp  = ctl_we && (ctl_addr == ADDR_CMP);
   assign wr_cnt  = ctl_we && (ctl_addr == ADDR_CNT);
   assign wr_irq  = ctl_we && (ctl_addr == ADDR_IRQ);
   assign unused_wbits = ^{ctl_wdata[CNT_W-1:7], ctl_wdata[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mode_q    <= MODE_WRAP;
         sel_q     <= 2'd0;
         ext_q     <= 1'b0;
         pin_act_q <= PIN_HOLD;
      end else if (wr_ctrl) begin
         en_q      <= ctl_wdata[0];
         mode_q    <= cnt_mode_t'(ctl_wdata[1]);
         sel_q     <= ctl_wdata[3:2];
         ext_q     <= ctl_wdata[4];
         pin_act_q <= pin_act_t'(ctl_wdata[6:5]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_cmp) cmp_q <= ctl_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_ie_q <= 1'b0;
         cmp_ie_q <= 1'b0;
         gie_q    <= 1'b0;
      end else if (wr_irq) begin
         ovf_ie_q <= ctl_wdata[0];
         cmp_ie_q <= ctl_wdata[1];
         gie_q    <= ctl_wdata[2];
      end
   end

   tmr_tick #(.PRE_STEP(PRE_STEP), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .sel     (sel_q),
      .ext_src (ext_q),
      .ext_pin (ext_evt_i),
      .tick    (tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .mode      (mode_q),
      .cmp_val   (cmp_q),
      .cnt_we    (wr_cnt),
      .cnt_wdata (ctl_wdata),
      .count     (count_o),
      .ovf_evt   (ovf_evt),
      .cmp_evt   (cmp_evt)
   );

   tmr_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_evt  (ovf_evt),
      .cmp_evt  (cmp_evt),
      .clr_ovf  (wr_irq && ctl_wdata[4]),
      .clr_cmp  (wr_irq && ctl_wdata[5]),
      .ack      (irq_ack_i),
      .gie      (gie_q),
      .ovf_ie   (ovf_ie_q),
      .cmp_ie   (cmp_ie_q),
      .pin_act  (pin_act_q),
      .ovf_flag (ovf_flag_o),
      .cmp_flag (cmp_flag_o),
      .irq      (irq_o),
      .pin      (cmp_pin_o)
   );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [1:0]       ctl_addr,
   input logic [CNT_W-1:0] ctl_wdata,
   input logic             irq_ack_i,
   input logic             irq_o,
   input logic             cmp_pin_o,
   input logic [CNT_W-1:0] count_o,
   input logic             ovf_flag_o,
   input logic             cmp_flag_o,
   input logic             en_q,
   input cnt_mode_t        mode_q,
   input logic             gie_q,
   input pin_act_t         pin_act_q,
   input logic             ovf_evt,
   input logic             cmp_evt
);
   // R2
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en_q) && !$past(ctl_we && ctl_addr == ADDR_CNT)) |-> $stable(count_o));

   // R4
   ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_evt) |-> (count_o == '0 && ovf_flag_o));

   // R5
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_evt) && $past(mode_q == MODE_CLR)) |-> (count_o == '0 && cmp_flag_o));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag_o) |-> ($past(ctl_we && ctl_addr == ADDR_IRQ && ctl_wdata[4])
                            || $past(irq_ack_i && gie_q)));

   // R7
   cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmp_flag_o) |-> ($past(ctl_we && ctl_addr == ADDR_IRQ && ctl_wdata[5])
                            || $past(irq_ack_i && gie_q)));

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |-> !irq_o);

   // R10
   pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_evt && pin_act_q == PIN_SET) |-> cmp_pin_o);

   // R10
   pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_evt && pin_act_q == PIN_CLEAR) |-> !cmp_pin_o);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .ctl_addr   (ctl_addr),
   .ctl_wdata  (ctl_wdata),
   .irq_ack_i  (irq_ack_i),
   .irq_o      (irq_o),
   .cmp_pin_o  (cmp_pin_o),
   .count_o    (count_o),
   .ovf_flag_o (ovf_flag_o),
   .cmp_flag_o (cmp_flag_o),
   .en_q       (en_q),
   .mode_q     (mode_q),
   .gie_q      (gie_q),
   .pin_act_q  (pin_act_q),
   .ovf_evt    (ovf_evt),
   .cmp_evt    (cmp_evt)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       we;
   logic [1:0] addr;
   logic [7:0] wdata;
   logic       ext;
   logic       ack_i;
   logic       irq;
   logic       pin;
   logic [7:0] count;
   logic       ovf;
   logic       cmpf;

   int nerr = 0;
   int nchk = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (we),
      .ctl_addr   (addr),
      .ctl_wdata  (wdata),
      .ext_evt_i  (ext),
      .irq_ack_i  (ack_i),
      .irq_o      (irq),
      .cmp_pin_o  (pin),
      .count_o    (count),
      .ovf_flag_o (ovf),
      .cmp_flag_o (cmpf)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse_ack();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pin_period(output int n);
      logic p;
      p = pin;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (pin != p) break;
      end
      p = pin;
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         n++;
         if (pin != p) break;
      end
   endtask

   task automatic cnt_period(output int n);
      logic [7:0] c;
      c = count;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (count != c) break;
      end
      c = count;
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         n++;
         if (count != c) break;
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog R1: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int n;
      logic [7:0] snap;
      rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = 8'd0; ext = 1'b0; ack_i = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 ovf flag", ovf, 0);
      chk("R1 cmp flag", cmpf, 0);
      chk("R1 irq", irq, 0);
      chk("R1 pin", pin, 0);

      // R4 wrap with overflow in the zero cycle; R8 clear collides with event
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h30);
      wr(2'd2, 8'hF0);
      wr(2'd0, 8'h01);
      step(14);
      chk("R4 count before wrap", count, 8'hFE);
      step(1);
      chk("R4 count at max", count, 8'hFF);
      chk("R4 ovf not yet", ovf, 0);
      wr(2'd3, 8'h10);
      chk("R4 count wrapped to zero", count, 0);
      chk("R8 event beats clear", ovf, 1);
      step(3);
      chk("R7 ovf flag sticky", ovf, 1);
      wr(2'd3, 8'h10);
      chk("R7 ovf flag cleared by write", ovf, 0);

      // R11 count write wins over a tick
      wr(2'd2, 8'h33);
      chk("R11 count loaded", count, 8'h33);
      step(1);
      chk("R11 count resumes", count, 8'h34);

      // R4 overflow period through pin toggle in wrap mode
      wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h40); wr(2'd0, 8'h21);
      pin_period(n);
      chk("R4 wrap period", n, 256);

      // R2 prescale ratios
      for (int s = 0; s < 4; s++) begin
         wr(2'd0, 8'h00);
         wr(2'd2, 8'h00);
         wr(2'd0, 8'(8'h01 | (s << 2)));
         cnt_period(n);
         chk("R2 prescale ratio", n, 1 << (3 * s));
         wr(2'd0, 8'h00);
         snap = count;
         step(20);
         chk("R2 disabled count holds", count, snap);
      end

      // R2 divider restarts after a disable
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h05);
      step(7);
      chk("R2 first tick not early", count, 0);
      step(1);
      chk("R2 first tick after 8", count, 1);
      step(3);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h05);
      step(7);
      chk("R2 restart not early", count, 1);
      step(1);
      chk("R2 restart full ratio", count, 2);

      // R5 sweep of every compare value, clear mode, ratio 1, toggle
      for (int c = 0; c < 256; c++) begin
         wr(2'd0, 8'h00);
         wr(2'd2, 8'h00);
         wr(2'd1, 8'(c));
         wr(2'd0, 8'h23);
         pin_period(n);
         chk("R5 clear-mode period", n, c + 1);
      end

      // R5 with ratio 8
      for (int k = 0; k < 3; k++) begin
         int c;
         c = (k == 0) ? 0 : ((k == 1) ? 3 : 17);
         wr(2'd0, 8'h00);
         wr(2'd2, 8'h00);
         wr(2'd1, 8'(c));
         wr(2'd0, 8'h27);
         pin_period(n);
         chk("R5 clear-mode period ratio 8", n, 8 * (c + 1));
      end

      // R10 pin actions
      wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h05);
      wr(2'd0, 8'h63);
      step(10);
      chk("R10 pin set action", pin, 1);
      wr(2'd0, 8'h43);
      step(10);
      chk("R10 pin clear action", pin, 0);
      wr(2'd0, 8'h03);
      step(20);
      chk("R10 pin hold action", pin, 0);

      // R6 compare lowered below count
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h30);
      wr(2'd2, 8'h80);
      wr(2'd1, 8'h10);
      wr(2'd0, 8'h03);
      step(127);
      chk("R6 count reaches max", count, 8'hFF);
      chk("R6 no early match", cmpf, 0);
      step(1);
      chk("R6 wrap to zero", count, 0);
      chk("R6 overflow on wrap", ovf, 1);
      step(16);
      chk("R6 reaches compare value", count, 8'h10);
      chk("R6 no match yet", cmpf, 0);
      step(1);
      chk("R6 match on next pass restarts", count, 0);
      chk("R6 compare flag set", cmpf, 1);
      wr(2'd0, 8'h00);

      // R9 interrupt request and acknowledge
      wr(2'd3, 8'h03);
      chk("R9 irq off without global enable", irq, 0);
      pulse_ack();
      chk("R9 ack ignored: cmp flag", cmpf, 1);
      chk("R9 ack ignored: ovf flag", ovf, 1);
      wr(2'd3, 8'h06);
      chk("R9 irq from compare", irq, 1);
      wr(2'd3, 8'h07);
      pulse_ack();
      chk("R9 ack clears compare first", cmpf, 0);
      chk("R9 ovf still pending", ovf, 1);
      chk("R9 irq still high", irq, 1);
      pulse_ack();
      chk("R9 second ack clears overflow", ovf, 0);
      chk("R9 irq low after acks", irq, 0);
      wr(2'd3, 8'h00);

      // R3 external event source
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h11);
      step(20);
      chk("R3 clock not counted", count, 0);
      for (int i = 1; i <= 5; i++) begin
         ext = 1'b1;
         step(3);
         ext = 1'b0;
         step(4);
         chk("R3 one count per edge", count, i);
      end
      ext = 1'b1;
      step(40);
      ext = 1'b0;
      step(6);
      chk("R3 held level counts once", count, 6);

      summary();
      $finish;
   end
endmodule